// File: doc/BRIEF.md
# Performance Monitor Counter Bank

A bank of four 32-bit event counters used to profile a processor core. Each counter has two private control words. The first control word chooses one of 128 event lines to watch. It also holds three freeze controls: one for user mode, one for supervisor mode and one that software sets directly. A fourth bit lets the counter raise an overflow flag. The second control word scales counting. A 6-bit threshold and a 3-bit multiplier code form a limit, and a counter advances only after its event has been seen on more consecutive cycles than that limit.

Software reaches everything through a plain register port: a one-cycle write strobe and a combinational read. The port exposes the counters, both control words, and read-only copies of both control words that user-mode code may read. A mode input tells the bank on every clock whether the core runs in supervisor or user mode. Each counter drives a sticky overflow output.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter, every control word and every overflow output reads 0.
- R2: The address is {region[2:0], lane[1:0]}. Region 0 is the counter, 1 is control word A, 2 is control word B, 3 is the copy of A and 4 is the copy of B. Regions 5 to 7 read 0. A write to region 0 loads the counter with the write data.
- R3: In control word A, bits [6:0] select the event line. With a threshold of 0 the counter adds one on each clock edge where the selected event is high. Unused bits of both control words read 0.
- R4: Control word A bit 8 freezes the counter while supv_mode is 0. Bit 9 freezes it while supv_mode is 1. Bit 10 freezes it in either mode. A frozen counter keeps both its value and its scaling tally.
- R5: In control word B, bits [5:0] hold the threshold t and bits [10:8] hold the multiplier code k. The limit is L = t·2^k. With t > 0, the counter adds one on the (L+1)-th consecutive event cycle, and the tally then starts again from 0.
- R6: A cycle in which the selected event is low, while the counter is not frozen, restarts the tally at 0.
- R7: Control word A bit 11 enables overflow. When it is set, ovf_flag[i] rises on the same clock edge on which counter bit 31 goes from 0 to 1. The flag stays set until software writes the counter. With bit 11 clear, the flag stays 0.
- R8: The copy regions read the same value as the matching control word. Writes to the copy regions change nothing.
- R9: Each lane counts only its own selected event. Activity on one lane leaves the other counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| events | input | 128 | Event lines, one per event number |
| supv_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 5 | Write address {region, lane} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address {region, lane} |
| rd_data | output | 32 | Combinational read data |
| ovf_flag | output | 4 | Sticky overflow flag, one bit per counter |

## Verification
Register writes and counter updates take effect on the clock edge that samples them, so every result can be read back on the following falling edge. The bench drives events, mode and the write strobe on falling edges. It reads rd_data and ovf_flag one time step after a falling edge, once the preceding rising edge has been counted. A run of N event cycles is therefore checked right after the N-th rising edge, using a count the bench works out from N and the limit. In the freeze-tally sequence, the bench takes into account that a control write only affects counting from the edge after the one that stores it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int PMC_CNT_W = 32;
  localparam int PMC_EV_N  = 128;
  localparam int PMC_THR_W = 6;
  localparam int PMC_MUL_W = 3;

  // control word A field positions
  localparam int A_FRZ_USR = 8;
  localparam int A_FRZ_SUP = 9;
  localparam int A_FRZ_SW  = 10;
  localparam int A_OVF_EN  = 11;
  // control word B field positions
  localparam int B_MUL_LSB = 8;

  typedef enum logic [2:0] {
    REG_CNT  = 3'd0,
    REG_CTLA = 3'd1,
    REG_CTLB = 3'd2,
    REG_MIRA = 3'd3,
    REG_MIRB = 3'd4
  } reg_region_e;
endpackage

// File: rtl/pmc_ctl_regs.sv
module pmc_ctl_regs #(
  parameter int SEL_W  = 7,
  parameter int THR_W  = 6,
  parameter int MUL_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [3:0]        wr_flags,
  input  logic [THR_W-1:0]  wr_thr,
  input  logic [MUL_W-1:0]  wr_mul,
  output logic [SEL_W-1:0]  sel,
  output logic              frz_usr,
  output logic              frz_sup,
  output logic              frz_sw,
  output logic              ovf_en,
  output logic [THR_W-1:0]  thr,
  output logic [MUL_W-1:0]  mul,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b
);
  import pmc_pkg::*;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [3:0]       flg_q, flg_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [MUL_W-1:0] mul_q, mul_d;

  always_comb begin
    sel_d = sel_q;
    flg_d = flg_q;
    thr_d = thr_q;
    mul_d = mul_q;
    if (wr_a) begin
      sel_d = wr_sel;
      flg_d = wr_flags;
    end
    if (wr_b) begin
      thr_d = wr_thr;
      mul_d = wr_mul;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      flg_q <= '0;
      thr_q <= '0;
      mul_q <= '0;
    end else begin
      sel_q <= sel_d;
      flg_q <= flg_d;
      thr_q <= thr_d;
      mul_q <= mul_d;
    end
  end

  assign sel     = sel_q;
  assign frz_usr = flg_q[0];
  assign frz_sup = flg_q[1];
  assign frz_sw  = flg_q[2];
  assign ovf_en  = flg_q[3];
  assign thr     = thr_q;
  assign mul     = mul_q;

  always_comb begin
    word_a = '0;
    word_a[SEL_W-1:0]           = sel_q;
    word_a[A_OVF_EN:A_FRZ_USR]  = flg_q;
    word_b = '0;
    word_b[THR_W-1:0]                 = thr_q;
    word_b[B_MUL_LSB+MUL_W-1:B_MUL_LSB] = mul_q;
  end
endmodule

// File: rtl/pmc_scaler.sv
module pmc_scaler #(
  parameter int THR_W = 6,
  parameter int MUL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             ev,
  input  logic [THR_W-1:0] thr,
  input  logic [MUL_W-1:0] mul,
  output logic             inc
);
  localparam int LIM_W = THR_W + (1 << MUL_W) - 1;

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] tally_q, tally_d;

  assign limit = LIM_W'(thr) << mul;

  always_comb begin
    tally_d = tally_q;
    inc     = 1'b0;
    if (clr) begin
      tally_d = '0;
    end else if (!hold) begin
      if (!ev) begin
        tally_d = '0;
      end else if (thr == '0) begin
        inc     = 1'b1;
        tally_d = '0;
      end else if (tally_q >= limit) begin
        inc     = 1'b1;
        tally_d = '0;
      end else begin
        tally_d = LIM_W'(tally_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tally_q <= '0;
    else        tally_q <= tally_d;
  end

  // R4: a frozen lane keeps its tally
  assert_tally_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(tally_q));
  // R6: an idle event cycle restarts the tally
  assert_tally_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !ev) |=> (tally_q == '0));
  // R5: the tally steps by one or returns to zero
  assert_tally_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tally_q == '0 || tally_q == $past(tally_q) ||
              tally_q == LIM_W'($past(tally_q) + 1'b1)));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             ovf_en,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (load) begin
      cnt_d = load_val;
      ovf_d = 1'b0;
    end else if (inc) begin
      cnt_d = CNT_W'(cnt_q + 1'b1);
      if (ovf_en && !cnt_q[CNT_W-1] && cnt_d[CNT_W-1]) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !load) |=> ovf_q);
  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ovf_q);
  assert_ovf_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_en && !ovf_q && !load) |=> !ovf_q);
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank #(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = pmc_pkg::PMC_CNT_W,
  parameter int NUM_EV  = pmc_pkg::PMC_EV_N,
  parameter int THR_W   = pmc_pkg::PMC_THR_W,
  parameter int MUL_W   = pmc_pkg::PMC_MUL_W,
  localparam int IDX_W  = $clog2(NUM_CTR),
  localparam int ADDR_W = 3 + IDX_W,
  localparam int SEL_W  = $clog2(NUM_EV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EV-1:0]  events,
  input  logic               supv_mode,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic [NUM_CTR-1:0] ovf_flag
);
  import pmc_pkg::*;

  reg_region_e      wr_region, rd_region;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_region = reg_region_e'(wr_addr[ADDR_W-1:IDX_W]);
  assign rd_region = reg_region_e'(rd_addr[ADDR_W-1:IDX_W]);
  assign wr_idx    = wr_addr[IDX_W-1:0];
  assign rd_idx    = rd_addr[IDX_W-1:0];

  logic [CNT_W-1:0] cnt_v   [NUM_CTR];
  logic [CNT_W-1:0] word_a_v[NUM_CTR];
  logic [CNT_W-1:0] word_b_v[NUM_CTR];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
    logic             hit, wr_cnt, wr_a, wr_b;
    logic [SEL_W-1:0] sel;
    logic             frz_usr, frz_sup, frz_sw, ovf_en, frozen, ev, inc;
    logic [THR_W-1:0] thr;
    logic [MUL_W-1:0] mul;

    assign hit    = wr_en && (wr_idx == IDX_W'(i));
    assign wr_cnt = hit && (wr_region == REG_CNT);
    assign wr_a   = hit && (wr_region == REG_CTLA);
    assign wr_b   = hit && (wr_region == REG_CTLB);

    pmc_ctl_regs #(.SEL_W(SEL_W), .THR_W(THR_W), .MUL_W(MUL_W), .DATA_W(CNT_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_a     (wr_a),
      .wr_b     (wr_b),
      .wr_sel   (wr_data[SEL_W-1:0]),
      .wr_flags (wr_data[A_OVF_EN:A_FRZ_USR]),
      .wr_thr   (wr_data[THR_W-1:0]),
      .wr_mul   (wr_data[B_MUL_LSB+MUL_W-1:B_MUL_LSB]),
      .sel      (sel),
      .frz_usr  (frz_usr),
      .frz_sup  (frz_sup),
      .frz_sw   (frz_sw),
      .ovf_en   (ovf_en),
      .thr      (thr),
      .mul      (mul),
      .word_a   (word_a_v[i]),
      .word_b   (word_b_v[i])
    );

    assign frozen = frz_sw | (supv_mode ? frz_sup : frz_usr);
    assign ev     = events[sel];

    pmc_scaler #(.THR_W(THR_W), .MUL_W(MUL_W)) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_cnt),
      .hold  (frozen),
      .ev    (ev),
      .thr   (thr),
      .mul   (mul),
      .inc   (inc)
    );

    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt),
      .load_val (wr_data),
      .inc      (inc),
      .ovf_en   (ovf_en),
      .cnt      (cnt_v[i]),
      .ovf      (ovf_flag[i])
    );

    // R4: frozen counter holds its value unless software loads it
    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !wr_cnt) |=> $stable(cnt_v[i]));
    // R8: writes aimed at the copy regions leave the control words alone
    assert_mirror_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (wr_region == REG_MIRA || wr_region == REG_MIRB))
        |=> ($stable(word_a_v[i]) && $stable(word_b_v[i])));
  end

  always_comb begin
    unique case (rd_region)
      REG_CNT:  rd_data = cnt_v[rd_idx];
      REG_CTLA,
      REG_MIRA: rd_data = word_a_v[rd_idx];
      REG_CTLB,
      REG_MIRB: rd_data = word_b_v[rd_idx];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: tb/tb_pmc_bank.sv
module tb_pmc_bank;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] events;
  logic         supv_mode;
  logic         wr_en;
  logic [4:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [4:0]   rd_addr;
  logic [31:0]  rd_data;
  logic [3:0]   ovf_flag;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pmc_bank dut (
    .clk(clk), .rst_n(rst_n), .events(events), .supv_mode(supv_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  // {threshold[5:0], mult code[2:0], event cycles[15:0]}
  localparam int NV = 7;
  localparam logic [24:0] VEC [NV] = '{
    {6'd0,  3'd0, 16'd5},
    {6'd1,  3'd0, 16'd10},
    {6'd3,  3'd1, 16'd20},
    {6'd2,  3'd2, 16'd27},
    {6'd1,  3'd7, 16'd300},
    {6'd5,  3'd3, 16'd100},
    {6'd63, 3'd0, 16'd64}
  };

  function automatic logic [4:0] ad(input int region, input int lane);
    return {region[2:0], lane[1:0]};
  endfunction

  function automatic logic [31:0] expect_cnt(input int t, input int k, input int n);
    int lim;
    lim = t * (1 << k);
    if (t == 0) return n;
    return n / (lim + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input int bitn, input int n);
    events[bitn] = 1'b1;
    repeat (n) @(negedge clk);
    events[bitn] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] last_tab;
    rst_n = 1'b0; events = '0; supv_mode = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int l = 0; l < 4; l++) begin
      for (int r = 0; r < 5; r++) begin
        rd(ad(r, l), d);
        chk("R1 reset register", d, 32'h0);
      end
    end
    chk("R1 reset ovf_flag", {28'h0, ovf_flag}, 32'h0);

    // R2/R3/R8: field layout, copies, unmapped reads
    wr(ad(1, 0), 32'hFFFF_FFFF);
    wr(ad(2, 0), 32'hFFFF_FFFF);
    rd(ad(1, 0), d); chk("R3 control A unused bits", d, 32'h0000_0F7F);
    rd(ad(2, 0), d); chk("R3 control B unused bits", d, 32'h0000_073F);
    rd(ad(3, 0), d); chk("R8 copy of A", d, 32'h0000_0F7F);
    rd(ad(4, 0), d); chk("R8 copy of B", d, 32'h0000_073F);
    wr(ad(3, 0), 32'h0);
    wr(ad(4, 0), 32'h0);
    rd(ad(1, 0), d); chk("R8 copy write ignored A", d, 32'h0000_0F7F);
    rd(ad(2, 0), d); chk("R8 copy write ignored B", d, 32'h0000_073F);
    rd(ad(5, 0), d); chk("R2 unmapped region", d, 32'h0);
    wr(ad(0, 0), 32'h1234_5678);
    rd(ad(0, 0), d); chk("R2 counter load", d, 32'h1234_5678);
    wr(ad(1, 0), 32'h0);
    wr(ad(2, 0), 32'h0);

    // R3/R5: scaling table on lane 1, event 45
    wr(ad(1, 1), 32'd45);
    last_tab = '0;
    for (int v = 0; v < NV; v++) begin
      int t, k, n;
      t = int'(VEC[v][24:19]);
      k = int'(VEC[v][18:16]);
      n = int'(VEC[v][15:0]);
      wr(ad(2, 1), (32'(k) << 8) | 32'(t));
      wr(ad(0, 1), 32'h0);
      pulse(45, n);
      rd(ad(0, 1), d);
      last_tab = expect_cnt(t, k, n);
      chk("R5 scaled count (R3 when threshold 0)", d, last_tab);
    end

    // R4: mode and software freeze on lane 0, event 3
    wr(ad(2, 0), 32'h0);
    wr(ad(0, 0), 32'h0);
    wr(ad(1, 0), 32'h103);
    supv_mode = 1'b0; pulse(3, 4);
    rd(ad(0, 0), d); chk("R4 user freeze in user mode", d, 32'd0);
    supv_mode = 1'b1; pulse(3, 4);
    rd(ad(0, 0), d); chk("R4 user freeze in supervisor mode", d, 32'd4);
    wr(ad(1, 0), 32'h203);
    pulse(3, 3);
    rd(ad(0, 0), d); chk("R4 supervisor freeze in supervisor mode", d, 32'd4);
    supv_mode = 1'b0; pulse(3, 3);
    rd(ad(0, 0), d); chk("R4 supervisor freeze in user mode", d, 32'd7);
    wr(ad(1, 0), 32'h403);
    pulse(3, 2);
    rd(ad(0, 0), d); chk("R4 software freeze", d, 32'd7);

    // R4: freeze keeps the tally (limit 2)
    wr(ad(1, 0), 32'h3);
    wr(ad(2, 0), 32'h2);
    wr(ad(0, 0), 32'h0);
    events[3] = 1'b1;
    @(negedge clk);              // tally 1
    wr(ad(1, 0), 32'h403);       // tally 2, then frozen
    repeat (3) @(negedge clk);
    rd(ad(0, 0), d); chk("R4 no count while frozen", d, 32'd0);
    wr(ad(1, 0), 32'h3);         // still frozen at this edge
    @(negedge clk);              // tally 2 reached: count
    events[3] = 1'b0;
    rd(ad(0, 0), d); chk("R4 tally kept across freeze", d, 32'd1);

    // R6: idle cycle restarts the tally (limit 2)
    wr(ad(0, 0), 32'h0);
    pulse(3, 2);
    @(negedge clk);
    pulse(3, 2);
    rd(ad(0, 0), d); chk("R6 gap restarts tally", d, 32'd0);
    pulse(3, 3);
    rd(ad(0, 0), d); chk("R6 unbroken run counts", d, 32'd1);

    // R7/R9: overflow on lane 2 (enabled) and lane 3 (disabled), event 127
    wr(ad(1, 2), 32'h800 | 32'd127);
    wr(ad(1, 3), 32'd127);
    wr(ad(0, 2), 32'h7FFF_FFFF);
    wr(ad(0, 3), 32'h7FFF_FFFF);
    pulse(127, 1);
    rd(ad(0, 2), d); chk("R7 counter crosses bit 31", d, 32'h8000_0000);
    chk("R7 flag rises only where enabled", {28'h0, ovf_flag}, 32'h4);
    rd(ad(0, 3), d); chk("R9 lane 3 counted same event", d, 32'h8000_0000);
    pulse(127, 2);
    chk("R7 flag sticky", {28'h0, ovf_flag}, 32'h4);
    rd(ad(0, 1), d); chk("R9 lane 1 untouched", d, last_tab);
    rd(ad(0, 0), d); chk("R9 lane 0 untouched", d, 32'd1);
    wr(ad(0, 2), 32'd5);
    chk("R7 flag cleared by counter write", {28'h0, ovf_flag}, 32'h0);
    rd(ad(0, 2), d); chk("R7 counter reloaded", d, 32'd5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule